// File: doc/BRIEF.md
# Task Address-Set Differential Unit

This block observes a stream of memory accesses that is framed by task-start and task-stop pulses. For each task instance it records the distinct addresses the instance touched. The addresses are kept in the order in which each one was first seen. When an instance closes, the block compares its set with the set kept from the instance before it. It then streams out the signed difference at each position, one element per beat, over a valid/ready interface. A consumer such as a learning prefetcher can use this compact vector to spot task instances that repeat with a fixed offset pattern.

The access input is a valid/ready stream. The block lowers `acc_ready` while it drains a differential vector and for the one commit cycle that follows. An upstream source must hold `acc_valid`, the address and the write flag steady until a cycle in which `acc_ready` is high. The output stream follows the usual rules. Once `diff_valid` is high, the element, its index and its last marker stay fixed until a cycle in which `diff_ready` is also high. The marker pulses are plain control pins and are never back-pressured. A start pulse that lands while a vector drains is held and takes effect right after the commit.

Top module: `tad_unit`

## Requirements
- R1: A start pulse opens an instance and a stop pulse closes it. An access joins the set only in a cycle where an instance is already open and neither marker pulses. Accesses at any other time are accepted and discarded.
- R2: An address already held in the open instance's set is not added again.
- R3: Set positions follow the order of first access within the instance, with position 0 being the earliest.
- R4: The write flag has no effect on membership. A write and a read of the same address count as one member.
- R5: Element i on `diff_data` is the (AW+1)-bit two's-complement value of current address i minus previous address i. Negative and zero values are emitted like any other.
- R6: A set holds at most DEPTH (16) addresses. A new distinct address that arrives when the set is full is dropped and raises `overflow` one cycle later. `overflow` then stays high until the end of that instance's commit cycle.
- R7: The first instance after reset emits no elements. Its set becomes the reference.
- R8: When the two sets differ in size, elements are emitted only for the positions 0 to min(current, previous) - 1.
- R9: After the vector is emitted (or skipped), the current set replaces the reference and the current set is emptied. This holds even when the current set is shorter than the old reference.
- R10: A start pulse during an open instance closes that instance as a stop would. A new instance opens right after the commit, without a further pulse.
- R11: `diff_index` starts at 0 and rises by one per handshake. `diff_last` marks the final element. A stalled element keeps its data, index and last marker unchanged.
- R12: `acc_ready` is low whenever `diff_valid` is high and during the commit cycle. Out of reset, `acc_ready` is high and `diff_valid` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| task_start | input | 1 | One-cycle pulse that begins a task instance |
| task_stop | input | 1 | One-cycle pulse that ends a task instance |
| acc_valid | input | 1 | Access beat present |
| acc_ready | output | 1 | Block can take an access beat |
| acc_addr | input | AW (40) | Access address |
| acc_is_write | input | 1 | Access kind (1 = write), not used for membership |
| diff_valid | output | 1 | Differential element present |
| diff_ready | input | 1 | Consumer takes the element |
| diff_data | output | AW+1 (41) | Signed difference for the current position |
| diff_index | output | log2(DEPTH) (4) | Position of the element |
| diff_last | output | 1 | Element is the final one of the vector |
| overflow | output | 1 | Capacity was exceeded in the current instance |

## Verification
The bound checker watches the stream rules on every cycle. These are the stall stability, the index stepping and the start from zero, the input back-pressure during draining, and the stickiness of the overflow flag. The arithmetic of each element needs the directed scenarios, because it depends on whole histories of instances. So do set order and de-duplication, the short-set truncation, the replacement of the reference, the silence after reset, and the implicit close on a second start.

// File: rtl/tad_pkg.sv
package tad_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_OPEN   = 2'd1,
    PH_EMIT   = 2'd2,
    PH_COMMIT = 2'd3
  } tad_phase_e;
endpackage

// File: rtl/tad_addr_set.sv
module tad_addr_set #(
  parameter int DEPTH = 16,
  parameter int AW    = 40,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      ins_en,
  input  logic [AW-1:0]             ins_addr,
  output logic [DEPTH-1:0][AW-1:0]  entries,
  output logic [CW-1:0]             count,
  output logic                      overflow
);
  logic [DEPTH-1:0] match;
  logic             hit;
  logic             full;
  logic             add;

  // parallel membership lookup over the occupied slots
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = (CW'(i) < count) && (entries[i] == ins_addr);
  end

  assign hit  = |match;
  assign full = (count == CW'(DEPTH));
  assign add  = ins_en && !hit && !full;

  // each slot is written only when it is the next free one
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entries[i] <= '0;
      end else if (add && (count == CW'(i))) begin
        entries[i] <= ins_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (clear) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (ins_en && !hit) begin
      if (full) begin
        overflow <= 1'b1;
      end else begin
        count <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tad_ref_set.sv
module tad_ref_set #(
  parameter int DEPTH = 16,
  parameter int AW    = 40,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [DEPTH-1:0][AW-1:0]  src_entries,
  input  logic [CW-1:0]             src_count,
  output logic [DEPTH-1:0][AW-1:0]  ref_entries,
  output logic [CW-1:0]             ref_count,
  output logic                      ref_valid
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_keep
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ref_entries[i] <= '0;
      end else if (load) begin
        ref_entries[i] <= src_entries[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_count <= '0;
      ref_valid <= 1'b0;
    end else if (load) begin
      ref_count <= src_count;
      ref_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/tad_diff_ctrl.sv
module tad_diff_ctrl
  import tad_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 40,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_pulse,
  input  logic                      stop_pulse,
  input  logic                      in_valid,
  output logic                      in_ready,
  output logic                      ins_en,
  input  logic [DEPTH-1:0][AW-1:0]  cur_entries,
  input  logic [CW-1:0]             cur_count,
  input  logic [DEPTH-1:0][AW-1:0]  ref_entries,
  input  logic [CW-1:0]             ref_count,
  input  logic                      ref_valid,
  output logic                      commit,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic signed [AW:0]        out_data,
  output logic [IW-1:0]             out_index,
  output logic                      out_last
);
  tad_phase_e      phase_q, phase_d;
  logic            pend_q, pend_d;
  logic [CW-1:0]   idx_q, idx_d;
  logic [CW-1:0]   emit_len;
  logic            closing;
  logic            fire;
  logic [AW-1:0]   cur_sel;
  logic [AW-1:0]   ref_sel;

  assign emit_len = (cur_count < ref_count) ? cur_count : ref_count;
  assign closing  = (phase_q == PH_OPEN) && (start_pulse || stop_pulse);

  assign in_ready  = (phase_q == PH_IDLE) || (phase_q == PH_OPEN);
  assign ins_en    = in_valid && (phase_q == PH_OPEN) && !start_pulse && !stop_pulse;
  assign commit    = (phase_q == PH_COMMIT);
  assign out_valid = (phase_q == PH_EMIT);
  assign out_last  = out_valid && (idx_q == emit_len - 1'b1);
  assign fire      = out_valid && out_ready;

  assign out_index = idx_q[IW-1:0];
  assign cur_sel   = cur_entries[idx_q[IW-1:0]];
  assign ref_sel   = ref_entries[idx_q[IW-1:0]];
  assign out_data  = $signed({1'b0, cur_sel}) - $signed({1'b0, ref_sel});

  always_comb begin
    phase_d = phase_q;
    pend_d  = pend_q;
    idx_d   = idx_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_pulse) phase_d = PH_OPEN;
      end
      PH_OPEN: begin
        if (closing) begin
          pend_d  = start_pulse;
          idx_d   = '0;
          phase_d = (ref_valid && (emit_len != '0)) ? PH_EMIT : PH_COMMIT;
        end
      end
      PH_EMIT: begin
        if (start_pulse) pend_d = 1'b1;
        if (fire) begin
          if (out_last) begin
            phase_d = PH_COMMIT;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      PH_COMMIT: begin
        phase_d = (pend_q || start_pulse) ? PH_OPEN : PH_IDLE;
        pend_d  = 1'b0;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pend_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      pend_q  <= pend_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/tad_unit.sv
module tad_unit #(
  parameter int DEPTH = 16,
  parameter int AW    = 40,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 task_start,
  input  logic                 task_stop,
  input  logic                 acc_valid,
  output logic                 acc_ready,
  input  logic [AW-1:0]        acc_addr,
  input  logic                 acc_is_write,
  output logic                 diff_valid,
  input  logic                 diff_ready,
  output logic signed [AW:0]   diff_data,
  output logic [IW-1:0]        diff_index,
  output logic                 diff_last,
  output logic                 overflow
);
  logic [DEPTH-1:0][AW-1:0] cur_entries;
  logic [DEPTH-1:0][AW-1:0] ref_entries;
  logic [CW-1:0]            cur_count;
  logic [CW-1:0]            ref_count;
  logic                     ref_valid;
  logic                     ins_en;
  logic                     commit;
  logic                     kind_unused;

  // membership ignores the access kind
  assign kind_unused = acc_is_write;

  tad_addr_set #(.DEPTH(DEPTH), .AW(AW)) cur_set_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (commit),
    .ins_en   (ins_en),
    .ins_addr (acc_addr),
    .entries  (cur_entries),
    .count    (cur_count),
    .overflow (overflow)
  );

  tad_ref_set #(.DEPTH(DEPTH), .AW(AW)) ref_set_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (commit),
    .src_entries (cur_entries),
    .src_count   (cur_count),
    .ref_entries (ref_entries),
    .ref_count   (ref_count),
    .ref_valid   (ref_valid)
  );

  tad_diff_ctrl #(.DEPTH(DEPTH), .AW(AW)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_pulse (task_start),
    .stop_pulse  (task_stop),
    .in_valid    (acc_valid),
    .in_ready    (acc_ready),
    .ins_en      (ins_en),
    .cur_entries (cur_entries),
    .cur_count   (cur_count),
    .ref_entries (ref_entries),
    .ref_count   (ref_count),
    .ref_valid   (ref_valid),
    .commit      (commit),
    .out_valid   (diff_valid),
    .out_ready   (diff_ready),
    .out_data    (diff_data),
    .out_index   (diff_index),
    .out_last    (diff_last)
  );
endmodule

// File: rtl/tad_unit_chk.sv
module tad_unit_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 40,
  localparam int IW   = $clog2(DEPTH)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_ready,
  input logic               diff_valid,
  input logic               diff_ready,
  input logic signed [AW:0] diff_data,
  input logic [IW-1:0]      diff_index,
  input logic               diff_last,
  input logic               overflow
);
  assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (diff_valid && !diff_ready) |=> (diff_valid && $stable(diff_data) &&
                                     $stable(diff_index) && $stable(diff_last)));

  assert_index_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (diff_valid && diff_ready && !diff_last) |=>
      (diff_valid && (diff_index == $past(diff_index) + 1'b1)));

  assert_index_from_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(diff_valid) |-> (diff_index == '0));

  assert_no_input_while_drain_R12: assert property (@(posedge clk) disable iff (!rst_n)
    diff_valid |-> !acc_ready);

  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && acc_ready) |=> overflow);

  assert_last_has_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    diff_last |-> diff_valid);
endmodule

bind tad_unit tad_unit_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_ready  (acc_ready),
  .diff_valid (diff_valid),
  .diff_ready (diff_ready),
  .diff_data  (diff_data),
  .diff_index (diff_index),
  .diff_last  (diff_last),
  .overflow   (overflow)
);

// File: tb/tad_unit_tb_top.sv
module tad_unit_tb_top;
  localparam int AW    = 40;
  localparam int DEPTH = 16;
  localparam int IW    = $clog2(DEPTH);

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               task_start = 1'b0;
  logic               task_stop = 1'b0;
  logic               acc_valid = 1'b0;
  logic               acc_ready;
  logic [AW-1:0]      acc_addr = '0;
  logic               acc_is_write = 1'b0;
  logic               diff_valid;
  logic               diff_ready = 1'b0;
  logic signed [AW:0] diff_data;
  logic [IW-1:0]      diff_index;
  logic               diff_last;
  logic               overflow;

  int n_tests = 0;
  int n_fails = 0;

  // reference model state, built from the requirements
  logic [AW-1:0] prev_set [DEPTH];
  int            prev_n  = 0;
  bit            prev_ok = 1'b0;
  logic [AW-1:0] cur_set [DEPTH];
  int            cur_n   = 0;

  always #2 clk = ~clk;

  tad_unit #(.DEPTH(DEPTH), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_stop(task_stop),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
    .acc_is_write(acc_is_write), .diff_valid(diff_valid), .diff_ready(diff_ready),
    .diff_data(diff_data), .diff_index(diff_index), .diff_last(diff_last),
    .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW:0] expect_diff(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return {1'b0, a} - {1'b0, b};
  endfunction

  task automatic model_add(input logic [AW-1:0] a);
    for (int i = 0; i < cur_n; i++) if (cur_set[i] == a) return;
    if (cur_n < DEPTH) begin
      cur_set[cur_n] = a;
      cur_n++;
    end
  endtask

  task automatic pulse_start();
    task_start = 1'b1;
    @(negedge clk);
    task_start = 1'b0;
  endtask

  task automatic pulse_stop();
    task_stop = 1'b1;
    @(negedge clk);
    task_stop = 1'b0;
  endtask

  task automatic access(input logic [AW-1:0] a, input bit wr, input bit counted);
    int waitc = 0;
    acc_valid    = 1'b1;
    acc_addr     = a;
    acc_is_write = wr;
    while (!acc_ready && waitc < 100) begin
      @(negedge clk);
      waitc++;
    end
    @(negedge clk);
    acc_valid = 1'b0;
    if (counted) model_add(a);
  endtask

  // drains or awaits the vector of the instance that just closed
  task automatic expect_vector(input string req);
    int m;
    int waitc;
    m = prev_ok ? ((cur_n < prev_n) ? cur_n : prev_n) : 0;
    if (m == 0) begin
      for (int c = 0; c < 4; c++) begin
        check(!diff_valid, req, "unexpected element", 64'(diff_valid), 64'd0);
        @(negedge clk);
      end
    end else begin
      for (int k = 0; k < m; k++) begin
        waitc = 0;
        while (!diff_valid && waitc < 50) begin
          @(negedge clk);
          waitc++;
        end
        check(diff_index == IW'(k), req, "index", 64'(diff_index), 64'(k));
        check(diff_data == expect_diff(cur_set[k], prev_set[k]), req, "element value",
              64'(diff_data), 64'(expect_diff(cur_set[k], prev_set[k])));
        check(diff_last == (k == m - 1), req, "last marker", 64'(diff_last), 64'(k == m - 1));
        if (k == 0) check(!acc_ready, "R12", "acc_ready while draining", 64'(acc_ready), 64'd0);
        if (k == 1) begin
          @(negedge clk);
          check(diff_valid && diff_index == IW'(k), "R11", "stalled element held",
                64'(diff_index), 64'(k));
        end
        diff_ready = 1'b1;
        @(negedge clk);
        diff_ready = 1'b0;
      end
    end
    waitc = 0;
    while (!acc_ready && waitc < 50) begin
      @(negedge clk);
      waitc++;
    end
    check(acc_ready, req, "returns to accepting", 64'(acc_ready), 64'd1);
    check(!overflow, "R6", "overflow cleared after commit", 64'(overflow), 64'd0);
    for (int i = 0; i < DEPTH; i++) prev_set[i] = cur_set[i];
    prev_n  = cur_n;
    prev_ok = 1'b1;
    cur_n   = 0;
  endtask

  task automatic t_reset();
    check(!diff_valid, "R12", "reset diff_valid", 64'(diff_valid), 64'd0);
    check(acc_ready, "R12", "reset acc_ready", 64'(acc_ready), 64'd1);
    check(!overflow, "R12", "reset overflow", 64'(overflow), 64'd0);
  endtask

  task automatic t_first_instance();  // R7
    pulse_start();
    access(40'h10000, 0, 1);
    access(40'h60000, 0, 1);
    access(40'h8000000, 0, 1);
    access(40'h7F00000, 1, 1);
    access(40'hFE000, 0, 1);
    pulse_stop();
    expect_vector("R7");
  endtask

  task automatic t_dedup_and_kind();  // R2 R4 R5
    pulse_start();
    access(40'h10020, 0, 1);
    access(40'h60060, 1, 1);
    access(40'h10020, 1, 1);
    access(40'h8000008, 0, 1);
    access(40'h60060, 0, 1);
    access(40'h7F00040, 1, 1);
    access(40'hFE060, 0, 1);
    check(cur_n == 5, "R2", "model set size", 64'(cur_n), 64'd5);
    pulse_stop();
    expect_vector("R2_R4_R5");
  endtask

  task automatic t_order_and_sign();  // R3 R5
    pulse_start();
    access(40'h10020, 0, 1);
    access(40'h60000, 0, 1);
    access(40'hFE060, 1, 1);
    access(40'h8000008, 0, 1);
    access(40'h7F00040, 0, 1);
    pulse_stop();
    expect_vector("R3_R5");
  endtask

  task automatic t_short_sets();  // R8 R9
    pulse_start();
    access(40'h200, 0, 1);
    access(40'h100, 0, 1);
    pulse_stop();
    expect_vector("R8");
    pulse_start();
    access(40'h240, 0, 1);
    access(40'h080, 0, 1);
    access(40'h300, 0, 1);
    access(40'h400, 0, 1);
    pulse_stop();
    expect_vector("R9");
  endtask

  task automatic t_overflow();  // R6
    pulse_start();
    for (int i = 0; i < DEPTH; i++) access(40'h1000 + 40'(i * 64), i[0], 1);
    access(40'h1000, 0, 1);
    check(!overflow, "R6", "overflow before excess", 64'(overflow), 64'd0);
    access(40'hABC000, 0, 1);
    check(overflow, "R6", "overflow after excess", 64'(overflow), 64'd1);
    access(40'hABD000, 1, 1);
    check(overflow, "R6", "overflow sticky", 64'(overflow), 64'd1);
    pulse_stop();
    expect_vector("R6");
    pulse_start();
    for (int i = 0; i < DEPTH; i++) access(40'h5000 + 40'(i * 8), 0, 1);
    pulse_stop();
    expect_vector("R6");
  endtask

  task automatic t_restart();  // R10
    pulse_start();
    access(40'h7000, 0, 1);
    access(40'h7100, 0, 1);
    access(40'h6F00, 0, 1);
    pulse_start();
    expect_vector("R10");
    access(40'h7010, 0, 1);
    access(40'h7130, 0, 1);
    access(40'h6E00, 1, 1);
    pulse_stop();
    expect_vector("R10");
  endtask

  task automatic t_ignored();  // R1
    access(40'hDEAD000, 0, 0);
    task_start = 1'b1;
    acc_valid  = 1'b1;
    acc_addr   = 40'hBEEF000;
    @(negedge clk);
    task_start = 1'b0;
    acc_valid  = 1'b0;
    access(40'h7020, 0, 1);
    access(40'h7150, 0, 1);
    pulse_stop();
    expect_vector("R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_instance();
    t_dedup_and_kind();
    t_order_and_sign();
    t_short_sets();
    t_overflow();
    t_restart();
    t_ignored();
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fails);
    $finish;
  end
endmodule